// File: doc/BRIEF.md
# TDMA Quarterbit Frame Counter

This block keeps the frame position of a GSM TDMA timing generator, counted in quarterbits. It runs from the 13 MHz system clock. A divide-by-12 prescaler makes a one-cycle enable, and that enable steps a quarterbit count of 0 to 4999 through one 5000-quarterbit frame. From that count the block derives a timeslot index (eight timeslots of 625 quarterbits each) and one-cycle strobes. There is a strobe for each bit (four quarterbits), one for each timeslot boundary and one for each frame boundary. A frame number counter also advances once per frame and wraps at the hyperframe length of 2715648 frames.

A two-bit mode input selects the operating mode. In normal and reduced-sleep modes the count runs from the 13 MHz clock. In sleep mode the quarterbit clock is gated off, so all timing state holds still. When the system leaves sleep, slower logic outside this block has kept the alignment, and it returns that alignment through a load input. The load writes a quarterbit position and a frame number, so counting resumes in step.

Top module: `tdma_qb_timer`

## Requirements
- R1: In mode 2'b00 (normal) and in mode 2'b10 (reduced sleep), the quarterbit count advances by one every 12 clock cycles. Mode 2'b11 behaves as normal.
- R2: The quarterbit count runs from 0 to 4999 and returns to 0 on the step after 4999.
- R3: `slot_stb_o` is high for exactly one cycle, in the cycle when a counting step makes the quarterbit count a multiple of 625. In every cycle `slot_o` equals the quarterbit count divided by 625, rounded down.
- R4: `frame_stb_o` is high for one cycle, in the cycle when a counting step takes the count from 4999 to 0. In that cycle `slot_stb_o` is also high and `slot_o` is 0.
- R5: `bit_stb_o` is high for one cycle, in the cycle when a counting step makes the quarterbit count a multiple of 4.
- R6: The frame number becomes visible together with each frame strobe, increased by one. From 2715647 it goes to 0.
- R7: In mode 2'b01 (sleep), the quarterbit count, the timeslot index, the frame number and the prescaler phase all hold, and no strobe is raised.
- R8: A cycle with `load_i` high writes `load_qb_i` and `load_fn_i`, and they appear in the next cycle. The timeslot index is derived from the loaded count. No strobe is raised for a load. The prescaler restarts, so the first step after the load comes 12 cycles after it. A load works in any mode and takes priority over counting.
- R9: A load of a quarterbit count of 5000 or more writes 0. A load of a frame number of 2715648 or more writes 0.
- R10: While reset is held, and in the first cycle after it, the count, the timeslot index, the frame number and all strobes are 0. Leaving reset raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 normal, 01 sleep, 10 reduced sleep, 11 as normal |
| load_i | input | 1 | Write position and frame number |
| load_qb_i | input | 13 | Quarterbit count to load |
| load_fn_i | input | 22 | Frame number to load |
| qb_cnt_o | output | 13 | Quarterbit count within the frame |
| slot_o | output | 3 | Timeslot index |
| bit_stb_o | output | 1 | Bit boundary strobe |
| slot_stb_o | output | 1 | Timeslot boundary strobe |
| frame_stb_o | output | 1 | Frame boundary strobe |
| fn_o | output | 22 | Frame number |

## Verification
The hyperframe wrap of the frame number is the hardest case to reach from the ports, since free running would take millions of frames. The bench loads 2715647 with the count at 4999 and checks the single step that follows. At that step the frame, timeslot and bit strobes must all fire together with both counters returning to 0. A full frame run from reset is also compared, cycle by cycle, against an expected value worked out from the cycle number. Loads at 624 and 4375 then exercise the timeslot edges and the top slot.

// File: rtl/tdma_qb_pkg.sv
package tdma_qb_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_SLEEP   = 2'b01,
    MODE_REDUCED = 2'b10,
    MODE_SPARE   = 2'b11
  } tdma_mode_e;

  // quarterbit clock is gated only in sleep
  function automatic logic mode_runs(logic [1:0] mode);
    return mode != MODE_SLEEP;
  endfunction

  // true when q sits on a multiple of step
  function automatic logic on_grid(int q, int step);
    return (q % step) == 0;
  endfunction

  // timeslot holding quarterbit q
  function automatic int slot_of(int q, int qps, int slots);
    int s;
    s = 0;
    for (int i = 1; i < slots; i++)
      if (q >= i * qps) s = i;
    return s;
  endfunction

endpackage

// File: rtl/tdma_prescaler.sv
module tdma_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase;

  assign tick = run && !restart && (phase == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (restart)    phase <= '0;
    else if (tick)       phase <= '0;
    else if (run)        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/tdma_qb_count.sv
module tdma_qb_count
  import tdma_qb_pkg::*;
#(
  parameter int QB_PER_SLOT = 625,
  parameter int SLOTS       = 8,
  parameter int QB_PER_BIT  = 4,
  localparam int QPF = QB_PER_SLOT * SLOTS,
  localparam int QW  = $clog2(QPF),
  localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [QW-1:0] load_qb,
  output logic [QW-1:0] qb,
  output logic [SW-1:0] slot,
  output logic          bit_stb,
  output logic          slot_stb,
  output logic          frame_stb,
  output logic          frame_wrap
);
  logic [QW-1:0] qb_nxt;
  logic [QW-1:0] qb_ld;
  logic          nxt_on_slot;

  assign frame_wrap  = tick && (qb == QW'(QPF - 1));
  assign qb_nxt      = (qb == QW'(QPF - 1)) ? '0 : qb + 1'b1;
  assign qb_ld       = (int'(load_qb) < QPF) ? load_qb : '0;
  assign nxt_on_slot = on_grid(int'(qb_nxt), QB_PER_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qb        <= '0;
      slot      <= '0;
      bit_stb   <= 1'b0;
      slot_stb  <= 1'b0;
      frame_stb <= 1'b0;
    end else if (load) begin
      qb        <= qb_ld;
      slot      <= SW'(slot_of(int'(qb_ld), QB_PER_SLOT, SLOTS));
      bit_stb   <= 1'b0;
      slot_stb  <= 1'b0;
      frame_stb <= 1'b0;
    end else if (tick) begin
      qb        <= qb_nxt;
      if (nxt_on_slot) slot <= (qb_nxt == '0) ? '0 : slot + 1'b1;
      bit_stb   <= on_grid(int'(qb_nxt), QB_PER_BIT);
      slot_stb  <= nxt_on_slot;
      frame_stb <= (qb_nxt == '0);
    end else begin
      bit_stb   <= 1'b0;
      slot_stb  <= 1'b0;
      frame_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/tdma_frame_num.sv
module tdma_frame_num #(
  parameter int FN_WRAP = 2715648,
  localparam int FW = $clog2(FN_WRAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [FW-1:0] load_fn,
  output logic [FW-1:0] fn
);
  logic [FW-1:0] fn_ld;

  assign fn_ld = (int'(load_fn) < FN_WRAP) ? load_fn : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fn <= '0;
    else if (load)  fn <= fn_ld;
    else if (adv)   fn <= (fn == FW'(FN_WRAP - 1)) ? '0 : fn + 1'b1;
  end
endmodule

// File: rtl/tdma_qb_timer.sv
module tdma_qb_timer
  import tdma_qb_pkg::*;
#(
  parameter int DIV         = 12,
  parameter int QB_PER_SLOT = 625,
  parameter int SLOTS       = 8,
  parameter int QB_PER_BIT  = 4,
  parameter int FN_WRAP     = 2715648,
  localparam int QPF = QB_PER_SLOT * SLOTS,
  localparam int QW  = $clog2(QPF),
  localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int FW  = $clog2(FN_WRAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          load_i,
  input  logic [QW-1:0] load_qb_i,
  input  logic [FW-1:0] load_fn_i,
  output logic [QW-1:0] qb_cnt_o,
  output logic [SW-1:0] slot_o,
  output logic          bit_stb_o,
  output logic          slot_stb_o,
  output logic          frame_stb_o,
  output logic [FW-1:0] fn_o
);
  // named internal events, visible to the bound checker
  logic qb_run;
  logic qb_tick;
  logic frame_wrap;

  assign qb_run = mode_runs(mode_i);

  tdma_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (qb_run),
    .restart (load_i),
    .tick    (qb_tick)
  );

  tdma_qb_count #(
    .QB_PER_SLOT (QB_PER_SLOT),
    .SLOTS       (SLOTS),
    .QB_PER_BIT  (QB_PER_BIT)
  ) u_qb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (qb_tick),
    .load       (load_i),
    .load_qb    (load_qb_i),
    .qb         (qb_cnt_o),
    .slot       (slot_o),
    .bit_stb    (bit_stb_o),
    .slot_stb   (slot_stb_o),
    .frame_stb  (frame_stb_o),
    .frame_wrap (frame_wrap)
  );

  tdma_frame_num #(.FN_WRAP(FN_WRAP)) u_fn (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (frame_wrap),
    .load    (load_i),
    .load_fn (load_fn_i),
    .fn      (fn_o)
  );
endmodule

// File: rtl/tdma_qb_timer_chk.sv
module tdma_qb_timer_chk
  import tdma_qb_pkg::*;
#(
  parameter int DIV         = 12,
  parameter int QB_PER_SLOT = 625,
  parameter int SLOTS       = 8,
  parameter int FN_WRAP     = 2715648,
  localparam int QPF = QB_PER_SLOT * SLOTS,
  localparam int QW  = $clog2(QPF),
  localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int FW  = $clog2(FN_WRAP)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic          load_i,
  input logic [QW-1:0] qb_cnt_o,
  input logic [SW-1:0] slot_o,
  input logic          slot_stb_o,
  input logic          frame_stb_o,
  input logic [FW-1:0] fn_o,
  input logic          qb_tick
);
  // independent count of enabled cycles since the last step or load
  int gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap <= 0;
    else if (load_i || qb_tick)      gap <= 0;
    else if (mode_i != MODE_SLEEP)   gap <= gap + 1;
  end

  p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    qb_tick |-> gap == DIV - 1);

  p_qb_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(qb_cnt_o) < QPF);

  p_qb_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qb_cnt_o != $past(qb_cnt_o)) && !$past(load_i) |->
      (int'(qb_cnt_o) == int'($past(qb_cnt_o)) + 1) ||
      (qb_cnt_o == '0 && int'($past(qb_cnt_o)) == QPF - 1));

  p_slot_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb_o |-> (int'(qb_cnt_o) % QB_PER_SLOT) == 0);

  p_slot_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_o) == int'(qb_cnt_o) / QB_PER_SLOT);

  p_frame_slot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |-> slot_stb_o && slot_o == '0 && qb_cnt_o == '0);

  p_fn_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o && !$past(load_i) |->
      int'(fn_o) == ((int'($past(fn_o)) + 1) % FN_WRAP));

  p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SLEEP) && !load_i |=> $stable(qb_cnt_o) && $stable(fn_o) && !slot_stb_o);
endmodule

bind tdma_qb_timer tdma_qb_timer_chk #(
  .DIV         (DIV),
  .QB_PER_SLOT (QB_PER_SLOT),
  .SLOTS       (SLOTS),
  .FN_WRAP     (FN_WRAP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .load_i      (load_i),
  .qb_cnt_o    (qb_cnt_o),
  .slot_o      (slot_o),
  .slot_stb_o  (slot_stb_o),
  .frame_stb_o (frame_stb_o),
  .fn_o        (fn_o),
  .qb_tick     (qb_tick)
);

// File: tb/tb_tdma_qb_timer.sv
module tb_tdma_qb_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        load_i = 1'b0;
  logic [12:0] load_qb_i = '0;
  logic [21:0] load_fn_i = '0;
  logic [12:0] qb_cnt_o;
  logic [2:0]  slot_o;
  logic        bit_stb_o, slot_stb_o, frame_stb_o;
  logic [21:0] fn_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tdma_qb_timer dut (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .load_i (load_i),
    .load_qb_i (load_qb_i), .load_fn_i (load_fn_i), .qb_cnt_o (qb_cnt_o),
    .slot_o (slot_o), .bit_stb_o (bit_stb_o), .slot_stb_o (slot_stb_o),
    .frame_stb_o (frame_stb_o), .fn_o (fn_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input int qb, input int fn);
    load_qb_i = 13'(qb);
    load_fn_i = 22'(fn);
    load_i    = 1'b1;
    step(1);
    load_i    = 1'b0;
  endtask

  function automatic int strobes();
    return int'(bit_stb_o) + int'(slot_stb_o) + int'(frame_stb_o);
  endfunction

  // R10: reset values
  task automatic t_reset();
    step(3);
    chk(qb_cnt_o == 0 && slot_o == 0 && fn_o == 0, "R10", "state in reset",
        int'(qb_cnt_o) + int'(slot_o) + int'(fn_o), 0);
    rst_n = 1'b1;
    step(1);
    chk(strobes() == 0 && qb_cnt_o == 0, "R10", "first cycle after reset",
        strobes() + int'(qb_cnt_o), 0);
  endtask

  // R1..R6: one full frame compared cycle by cycle
  task automatic t_full_frame();
    int bad_qb = 0, bad_slot = 0, bad_bit = 0, bad_sstb = 0, bad_fstb = 0;
    int n_slot = 0, n_frame = 0, n_bit = 0;
    for (int n = 2; n <= 60001; n++) begin
      int q, e_slot;
      bit stp;
      step(1);
      q      = (n / 12) % 5000;
      stp    = (n % 12) == 0;
      e_slot = q / 625;
      if (int'(qb_cnt_o) != q) bad_qb++;
      if (int'(slot_o) != e_slot) bad_slot++;
      if (bit_stb_o != (stp && (q % 4) == 0)) bad_bit++;
      if (slot_stb_o != (stp && (q % 625) == 0)) bad_sstb++;
      if (frame_stb_o != (stp && q == 0)) bad_fstb++;
      n_slot  += int'(slot_stb_o);
      n_frame += int'(frame_stb_o);
      n_bit   += int'(bit_stb_o);
    end
    chk(bad_qb == 0, "R1", "quarterbit mismatch cycles", bad_qb, 0);
    chk(bad_qb == 0 && qb_cnt_o == 0, "R2", "count after one frame", int'(qb_cnt_o), 0);
    chk(bad_slot == 0, "R3", "slot index mismatch cycles", bad_slot, 0);
    chk(bad_sstb == 0 && n_slot == 8, "R3", "slot strobes per frame", n_slot, 8);
    chk(bad_fstb == 0 && n_frame == 1, "R4", "frame strobes per frame", n_frame, 1);
    chk(bad_bit == 0 && n_bit == 1250, "R5", "bit strobes per frame", n_bit, 1250);
    chk(fn_o == 1, "R6", "frame number after one frame", int'(fn_o), 1);
  endtask

  // R7: sleep holds everything, then resumes
  task automatic t_sleep();
    logic [12:0] q0;
    logic [21:0] f0;
    int moved = 0, pulses = 0;
    step(5);
    mode_i = 2'b01;
    step(1);
    q0 = qb_cnt_o;
    f0 = fn_o;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (qb_cnt_o != q0 || fn_o != f0) moved++;
      pulses += strobes();
    end
    chk(moved == 0, "R7", "cycles with motion in sleep", moved, 0);
    chk(pulses == 0, "R7", "strobes in sleep", pulses, 0);
    mode_i = 2'b00;
    step(12);
    chk(int'(qb_cnt_o) == int'(q0) + 1, "R7", "single step after wake",
        int'(qb_cnt_o), int'(q0) + 1);
  endtask

  // R8: load in sleep, restart of prescaler, slot edge at 625
  task automatic t_load_slot_edge();
    mode_i = 2'b01;
    step(2);
    do_load(624, 77);
    chk(qb_cnt_o == 624 && fn_o == 77 && slot_o == 0, "R8", "loaded position",
        int'(qb_cnt_o), 624);
    chk(strobes() == 0, "R8", "no strobe on load", strobes(), 0);
    mode_i = 2'b00;
    step(11);
    chk(qb_cnt_o == 624, "R8", "held 11 cycles after load", int'(qb_cnt_o), 624);
    step(1);
    chk(qb_cnt_o == 625 && slot_o == 1 && slot_stb_o, "R3", "slot edge at 625",
        int'(slot_o), 1);
    chk(!bit_stb_o && !frame_stb_o, "R5", "625 is not a bit edge",
        int'(bit_stb_o), 0);
    do_load(4375, 3);
    chk(slot_o == 7, "R8", "slot derived from 4375", int'(slot_o), 7);
  endtask

  // R6/R4/R5: hyperframe wrap via a load near the end
  task automatic t_hyper_wrap();
    mode_i = 2'b00;
    do_load(4999, 2715647);
    step(12);
    chk(qb_cnt_o == 0 && fn_o == 0, "R6", "frame number wraps to 0", int'(fn_o), 0);
    chk(frame_stb_o && slot_stb_o && bit_stb_o && slot_o == 0, "R4",
        "all strobes at frame boundary", strobes(), 3);
  endtask

  // R9: out-of-range loads
  task automatic t_range();
    do_load(5000, 2715648);
    chk(qb_cnt_o == 0, "R9", "quarterbit clamp", int'(qb_cnt_o), 0);
    chk(fn_o == 0, "R9", "frame number clamp", int'(fn_o), 0);
  endtask

  // R1: reduced sleep and spare mode count like normal
  task automatic t_modes();
    mode_i = 2'b10;
    do_load(100, 5);
    step(12);
    chk(qb_cnt_o == 101, "R1", "reduced sleep first step", int'(qb_cnt_o), 101);
    step(12);
    chk(qb_cnt_o == 102, "R1", "reduced sleep second step", int'(qb_cnt_o), 102);
    mode_i = 2'b11;
    step(12);
    chk(qb_cnt_o == 103, "R1", "mode 11 as normal", int'(qb_cnt_o), 103);
    mode_i = 2'b00;
  endtask

  initial begin
    t_reset();
    t_full_frame();
    t_sleep();
    t_load_slot_edge();
    t_hyper_wrap();
    t_range();
    t_modes();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule